// File: doc/BRIEF.md
# Processor Return-Address Stack with Carry Save

This block keeps return addresses for a small 4-bit processor core. The core pushes a frame whenever it enters a subroutine or accepts an interrupt. Each frame holds the 11 low bits of the program counter for the instruction that follows the call, plus the carry flag as it stood at that moment. Calls and interrupts share the same four levels.

There are two kinds of return, and both pop a frame. After an interrupt-style return the core takes back both the address and the saved carry. After a value-style return it takes back only the address, and its live carry passes through unchanged.

The stack is a shift register. The top frame is always visible on the output. A push beyond four levels silently discards the deepest frame. A pop with nothing stored repeats what the deepest slot held.

Top module: `rstk_top`

## Requirements
- R1: Frames come back in last-in, first-out order. During a cycle with `pop_i` high, `ret_addr_o` shows the most recently pushed frame that has not yet been popped.
- R2: A push stores all 11 bits of `next_pc_i` unchanged. From the cycle after a push, `ret_addr_o` shows the value just pushed, including the extremes 0x000 and 0x7FF.
- R3: When a fifth push arrives with four frames held, the oldest frame is lost and nothing flags it. The next four pops return the four newest frames. The occupancy count never exceeds four.
- R4: During a pop with `restore_cy_i` = 1 (interrupt-style return), `carry_o` equals the carry stored with the top frame.
- R5: During a pop with `restore_cy_i` = 0 (value-style return), `carry_o` equals `carry_i`, so the core's carry is left unchanged.
- R6: In any cycle without a pop, `carry_o` equals `carry_i`.
- R7: A pop with the stack empty leaves the count at zero. It returns the frame in the top slot, which after a full drain repeats the deepest frame that was last popped.
- R8: Synchronous active-high reset clears the occupancy count. The frame contents are not reset.
- R9: `push_i` and `pop_i` must never be high in the same cycle. An assertion flags it if they are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| push_i | input | 1 | Push strobe, for a call or an interrupt entry |
| pop_i | input | 1 | Pop strobe, for either return kind |
| restore_cy_i | input | 1 | Return kind: 1 = restore the saved carry, 0 = keep the live carry |
| next_pc_i | input | 11 | Address to save (PC+1, without the page bit) |
| carry_i | input | 1 | The core's current carry flag |
| ret_addr_o | output | 11 | Address in the top frame |
| carry_o | output | 1 | Carry the core should hold after this cycle |

## Verification
Two things can happen on the same clock edge: a push writes a new top frame while the shift drops the deepest one. The bench provokes this by pushing a fifth frame onto a full stack. It then drains the stack and checks that the four newest addresses come back in reverse order with their carries, and that the first frame never reappears. Further pops on the empty stack must return the deepest survivor again.

// File: rtl/rstk_pkg.sv
package rstk_pkg;

    localparam int unsigned ADDR_W = 11;

    typedef struct packed {
        logic              cy;
        logic [ADDR_W-1:0] addr;
    } frame_t;

endpackage

// File: rtl/rstk_occupancy.sv
module rstk_occupancy #(
    parameter int unsigned DEPTH = 4,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             push_i,
    input  logic             pop_i,
    output logic [CNT_W-1:0] count_o
);

    localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

    typedef struct packed {
        logic [CNT_W-1:0] count;
    } occ_state_t;

    occ_state_t occ_d, occ_q;

    always_comb begin
        occ_d = occ_q;
        if (push_i) begin
            if (occ_q.count != FULL) begin
                occ_d.count = occ_q.count + 1'b1;
            end
        end else if (pop_i) begin
            if (occ_q.count != '0) begin
                occ_d.count = occ_q.count - 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            occ_q <= '0;
        end else begin
            occ_q <= occ_d;
        end
    end

    assign count_o = occ_q.count;

    assert_no_overflow_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        occ_q.count <= FULL);

    assert_empty_pop_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        (pop_i && !push_i && occ_q.count == '0) |=> occ_q.count == '0);

    assert_reset_clear_R8: assert property (@(posedge clk_i)
        $past(rst_i) |-> occ_q.count == '0);

    assert_push_pop_exclusive_R9: assert property (@(posedge clk_i) disable iff (rst_i)
        !(push_i && pop_i));

endmodule

// File: rtl/rstk_store.sv
module rstk_store
    import rstk_pkg::*;
#(
    parameter int unsigned DEPTH = 4
) (
    input  logic   clk_i,
    input  logic   rst_i,
    input  logic   push_i,
    input  logic   pop_i,
    input  frame_t push_frame_i,
    output frame_t top_o
);

    typedef struct packed {
        frame_t [DEPTH-1:0] slot;
    } store_state_t;

    store_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (push_i) begin
            st_d.slot[0] = push_frame_i;
            for (int i = 1; i < DEPTH; i++) begin
                st_d.slot[i] = st_q.slot[i-1];
            end
        end else if (pop_i) begin
            for (int i = 0; i < DEPTH - 1; i++) begin
                st_d.slot[i] = st_q.slot[i+1];
            end
        end
    end

    always_ff @(posedge clk_i) begin
        st_q <= st_d;
    end

    assign top_o = st_q.slot[0];

    assert_push_top_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        (push_i && !pop_i) |=> st_q.slot[0] == $past(push_frame_i));

endmodule

// File: rtl/rstk_top.sv
module rstk_top
    import rstk_pkg::*;
#(
    parameter int unsigned DEPTH = 4
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              push_i,
    input  logic              pop_i,
    input  logic              restore_cy_i,
    input  logic [ADDR_W-1:0] next_pc_i,
    input  logic              carry_i,
    output logic [ADDR_W-1:0] ret_addr_o,
    output logic              carry_o
);

    localparam int unsigned CNT_W = $clog2(DEPTH + 1);

    frame_t           push_frame;
    frame_t           top_frame;
    logic [CNT_W-1:0] count;

    assign push_frame.addr = next_pc_i;
    assign push_frame.cy   = carry_i;

    rstk_store #(.DEPTH(DEPTH)) u_store (
        .clk_i        (clk_i),
        .rst_i        (rst_i),
        .push_i       (push_i),
        .pop_i        (pop_i),
        .push_frame_i (push_frame),
        .top_o        (top_frame)
    );

    rstk_occupancy #(.DEPTH(DEPTH)) u_occ (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .push_i  (push_i),
        .pop_i   (pop_i),
        .count_o (count)
    );

    always_comb begin
        ret_addr_o = top_frame.addr;
        carry_o    = carry_i;
        if (pop_i && restore_cy_i) begin
            carry_o = top_frame.cy;
        end
    end

    assert_pop_count_R1: assert property (@(posedge clk_i) disable iff (rst_i)
        (pop_i && !push_i && count != '0) |=> count == $past(count) - 1'b1);

endmodule

// File: tb/sim_rstk_top.sv
`timescale 1ns/1ps
module sim_rstk_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        push = 1'b0, pop = 1'b0, kind = 1'b0, cy_in = 1'b0;
    logic [10:0] pc = '0;
    logic [10:0] ret_addr;
    logic        cy_out;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    rstk_top u0 (
        .clk_i(clk), .rst_i(rst), .push_i(push), .pop_i(pop),
        .restore_cy_i(kind), .next_pc_i(pc), .carry_i(cy_in),
        .ret_addr_o(ret_addr), .carry_o(cy_out)
    );

    typedef struct { logic [10:0] addr; logic cy; string req; } exp_t;
    exp_t exp_q[$];

    logic [10:0] m_addr [4];
    logic        m_cy   [4];

    task automatic check(input string req, input logic [11:0] act, input logic [11:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, act, expv);
        end
    endtask

    task automatic do_push(input logic [10:0] a, input logic c);
        @(posedge clk); #1;
        push = 1'b1; pc = a; cy_in = c;
        for (int i = 3; i > 0; i--) begin m_addr[i] = m_addr[i-1]; m_cy[i] = m_cy[i-1]; end
        m_addr[0] = a; m_cy[0] = c;
        @(posedge clk); #1;
        push = 1'b0;
        check("R2", {1'b0, ret_addr}, {1'b0, a});
    endtask

    task automatic do_pop(input logic k, input logic live_cy, input string req);
        exp_t e;
        @(posedge clk); #1;
        pop = 1'b1; kind = k; cy_in = live_cy;
        e.addr = m_addr[0];
        e.cy   = k ? m_cy[0] : live_cy;
        e.req  = req;
        exp_q.push_back(e);
        for (int i = 0; i < 3; i++) begin m_addr[i] = m_addr[i+1]; m_cy[i] = m_cy[i+1]; end
        @(posedge clk); #1;
        pop = 1'b0;
    endtask

    // monitor: compares each pop against the scoreboard head
    always @(negedge clk) begin
        if (pop && exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            check(e.req, {1'b0, ret_addr}, {1'b0, e.addr});
            check(e.req, {11'b0, cy_out}, {11'b0, e.cy});
        end
    end

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        // R8 reset and R6 carry passthrough when idle
        cy_in = 1'b1; #1;
        check("R6", {11'b0, cy_out}, 12'd1);
        cy_in = 1'b0; #1;
        check("R8", {11'b0, cy_out}, 12'd0);

        // R1 R4: single frame, interrupt-style return restores carry
        do_push(11'h155, 1'b1);
        do_pop(1'b1, 1'b0, "R4");

        // R1 R5: LIFO with value-style returns keeping live carry
        do_push(11'h101, 1'b1);
        do_push(11'h202, 1'b0);
        do_push(11'h303, 1'b1);
        do_pop(1'b0, 1'b0, "R5");
        do_pop(1'b1, 1'b1, "R1");
        do_pop(1'b0, 1'b1, "R5");

        // R3: five pushes drop the oldest
        do_push(11'h011, 1'b0);
        do_push(11'h022, 1'b1);
        do_push(11'h033, 1'b0);
        do_push(11'h044, 1'b1);
        do_push(11'h055, 1'b0);
        do_pop(1'b1, 1'b1, "R3");
        do_pop(1'b1, 1'b0, "R3");
        do_pop(1'b1, 1'b1, "R3");
        do_pop(1'b1, 1'b0, "R3");
        // R7: empty pops repeat the deepest survivor (0x022)
        do_pop(1'b1, 1'b0, "R7");
        do_pop(1'b0, 1'b1, "R7");
        check("R7", {1'b0, ret_addr}, 12'h022);

        // R2 boundaries
        do_push(11'h7FF, 1'b1);
        do_push(11'h000, 1'b0);
        do_pop(1'b1, 1'b1, "R2");
        do_pop(1'b1, 1'b0, "R2");

        // R6: no pop, carry follows live value
        @(posedge clk); #1 cy_in = 1'b1; #1;
        check("R6", {11'b0, cy_out}, 12'd1);

        repeat (2) @(posedge clk);
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R1: got %0d pending expected 0", exp_q.size());
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule